// File: doc/BRIEF.md
# Stored-Procedure Debug Controller

This block sits beside a host datapath and gives it runtime debug hooks. The host signals an extension point by pulsing a label code. The controller then holds the host and runs, one after another, every stored procedure attached to that label. Each procedure is a short list of instructions in a deliberately weak language. It can increment, decrement and set counters, compare a counter against a constant, do a forward-only if/else, and load or store indexed array entries. Every procedure ends in continue or break.

If every attached procedure ends in continue, the host is released. If any one ends in break, the controller enters interactive mode and reports the label. A remote director can then read and write counters, rewrite stored procedures and finally resume the host. The controller comes out of reset in interactive mode, so the director can load procedures before the host first runs.

The counters are shared with the host through a small read, write and increment port. While the host is held, the controller owns them.

Top module: `dbg_ctrl`

## Requirements
- R1: After reset the controller is in interactive mode (`interactive`=1, `host_hold`=1), `brk_valid` and `rsp_valid` are 0, all counters read 0, and every procedure slot is empty.
- R2: An extension point whose slots are all empty (first word opcode 15) holds the host for exactly one cycle per slot (PSLOTS, default 2). It then releases the host with no break and no counter change.
- R3: Instruction word bits: [17:14] opcode, [13:11] counter A, [10:8] counter B, [7:0] immediate. Each instruction takes one cycle. Opcodes: 2 increments A, 3 decrements A, 4 sets A to the immediate, 0 is continue. All slots of the label run in order, and the host is released when all of them continue.
- R4: Opcode 1 (break) ends its slot, but the remaining slots still run. Afterwards `interactive` rises together with a one-cycle `brk_valid` that carries the label code on `brk_label`.
- R5: Director command codes are 0 read, 1 write, 2 place and 3 resume. Every command gets `rsp_valid` one cycle later. In interactive mode the host stays held while write and read are executed and acknowledged with `rsp_ok`=1. Only resume returns the controller to batch mode and releases the host.
- R6: A place command writes `cmd_data` to the instruction address {label, slot, index} (bits [5:4], [3], [2:0]). It is accepted only in interactive mode. Outside interactive mode, place and write are answered with `rsp_ok`=0 and change nothing.
- R7: Opcode 5 compares A with the immediate for equality, and opcode 6 compares it for unsigned less-than. The result is +1 when true and -1 otherwise, and it is -1 at the start of each slot. Opcode 7 (if) falls into the next instruction on +1 and skips the immediate count of instructions on -1. Opcode 8 skips the immediate count of instructions unconditionally.
- R8: Opcode 10 stores counter A into array[imm bit 0] at the index given by the low 3 bits of counter B. Opcode 9 loads that entry into counter A.
- R9: A slot that reaches its MAXI-th instruction (default 8) without a terminator, or that skips past the last instruction, is treated as a break.
- R10: The host port writes (`hv_we`) or increments (`hv_inc`) the counter at `hv_addr` only while `host_hold` is 0. `hv_rdata` always shows that counter. While the host is held, host writes are ignored and controller writes win.
- R11: A director read (code 0) is accepted in any mode and returns the counter value on `rsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xp_valid | input | 1 | One-cycle pulse: host reached an extension point |
| xp_label | input | 2 | Label code of the extension point |
| host_hold | output | 1 | Host must not advance while high |
| hv_addr | input | 3 | Host counter address (read and write) |
| hv_we | input | 1 | Host counter write |
| hv_inc | input | 1 | Host counter increment |
| hv_wdata | input | 8 | Host counter write data |
| hv_rdata | output | 8 | Counter value at hv_addr |
| cmd_valid | input | 1 | Director command strobe |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | 6 | Counter address (low bits) or instruction address |
| cmd_data | input | 18 | Write data (low 8 bits) or instruction word |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_ok | output | 1 | Command accepted |
| rsp_data | output | 8 | Read data |
| interactive | output | 1 | Interactive mode |
| brk_valid | output | 1 | One-cycle break report |
| brk_label | output | 2 | Label code that broke |

## Verification
A corrupted slot or instruction pointer shows at the ports within a few cycles. The host hold lasts a different number of cycles, or the counters read back through `hv_rdata` hold the wrong values once the hold drops. A lost break flag makes the controller release the host instead of raising `interactive` and `brk_valid` at the end of the last slot. A wrong comparison result swaps which counter an if/else pair writes, which is visible on the first read after the extension point. A mode error shows on the very next command as a wrong `rsp_ok`.

// File: rtl/dbgc_pkg.sv
// Shared encodings for the stored-procedure debug controller.
// Assumes a 4-bit opcode in the top bits of every instruction word.
package dbgc_pkg;
    typedef enum logic [3:0] {
        OP_CONT  = 4'd0,
        OP_BRK   = 4'd1,
        OP_INC   = 4'd2,
        OP_DEC   = 4'd3,
        OP_SET   = 4'd4,
        OP_CEQ   = 4'd5,
        OP_CLT   = 4'd6,
        OP_IF    = 4'd7,
        OP_SKIP  = 4'd8,
        OP_ALD   = 4'd9,
        OP_AST   = 4'd10,
        OP_EMPTY = 4'd15
    } op_e;

    typedef enum logic [1:0] {
        CMD_READ   = 2'd0,
        CMD_WRITE  = 2'd1,
        CMD_PLACE  = 2'd2,
        CMD_RESUME = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_BATCH = 2'd0,
        ST_RUN   = 2'd1,
        ST_INTER = 2'd2
    } st_e;
endpackage

// File: rtl/dbgc_varfile.sv
// Counter register file shared by host and controller.
// Does: NVAR counters with NRD combinational read ports. The controller
// write always wins. Host write/increment applies only when h_block is low.
// Assumes: NVAR is a power of two.
module dbgc_varfile #(
    parameter int VW   = 8,
    parameter int NVAR = 8,
    parameter int NRD  = 4,
    localparam int VAW = $clog2(NVAR)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     h_block,
    input  logic                     h_we,
    input  logic                     h_inc,
    input  logic [VAW-1:0]           h_addr,
    input  logic [VW-1:0]            h_wdata,
    input  logic                     c_we,
    input  logic [VAW-1:0]           c_addr,
    input  logic [VW-1:0]            c_wdata,
    input  logic [NRD-1:0][VAW-1:0]  rd_addr,
    output logic [NRD-1:0][VW-1:0]   rd_data
);
    logic [VW-1:0] v [NVAR];

    // Update counters: controller first, then the unblocked host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NVAR; i++) v[i] <= '0;
        end else begin
            for (int i = 0; i < NVAR; i++) begin
                if (c_we && c_addr == VAW'(i)) begin
                    v[i] <= c_wdata;
                end else if (!h_block && h_addr == VAW'(i)) begin
                    if (h_we)       v[i] <= h_wdata;
                    else if (h_inc) v[i] <= v[i] + 1'b1;
                end
            end
        end
    end

    // Combinational read ports
    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = v[rd_addr[r]];
    end

    // R10: a blocked host write leaves its counter unchanged
    a_r10_host_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (h_block && !c_we && (h_we || h_inc)) |=> (v[$past(h_addr)] == $past(v[h_addr])));
endmodule

// File: rtl/dbgc_arrfile.sv
// Debug arrays: NARR arrays of ADEPTH entries, one write and one read port.
// Assumes: NARR and ADEPTH are powers of two and at least 2.
module dbgc_arrfile #(
    parameter int VW     = 8,
    parameter int NARR   = 2,
    parameter int ADEPTH = 8,
    localparam int AIW   = $clog2(NARR),
    localparam int IXW   = $clog2(ADEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [AIW-1:0] id,
    input  logic [IXW-1:0] idx,
    input  logic [VW-1:0]  wdata,
    output logic [VW-1:0]  rdata
);
    localparam int NE = NARR * ADEPTH;
    logic [VW-1:0] mem [NE];

    // Store one entry, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) mem[i] <= '0;
        end else if (we) begin
            mem[{id, idx}] <= wdata;
        end
    end

    // Read the same entry the store would address
    assign rdata = mem[{id, idx}];
endmodule

// File: rtl/dbgc_procmem.sv
// Stored-procedure memory addressed by {label, slot, index}.
// Does: resets every word to an empty instruction and allows single-word rewrites.
// Assumes: address width covers NWORDS exactly.
module dbgc_procmem #(
    parameter int IW  = 18,
    parameter int PAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [PAW-1:0] waddr,
    input  logic [IW-1:0]  wdata,
    input  logic [PAW-1:0] raddr,
    output logic [IW-1:0]  rdata
);
    import dbgc_pkg::*;
    localparam int NWORDS = 1 << PAW;
    localparam logic [IW-1:0] EMPTY_W = {OP_EMPTY, {(IW-4){1'b0}}};
    logic [IW-1:0] mem [NWORDS];

    // Rewrite one instruction; reset marks every slot empty
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) mem[i] <= EMPTY_W;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dbgc_seq.sv
// Mode FSM, procedure sequencer and director command handling.
// Does: runs every slot of a label one instruction per cycle, gathers
// breaks, enters interactive mode and serves director commands.
// Assumes: PSLOTS, MAXI, NLBL are powers of two >= 2; xp_valid is a one-cycle pulse.
module dbgc_seq #(
    parameter int VW     = 8,
    parameter int VAW    = 3,
    parameter int LW     = 2,
    parameter int SW     = 1,
    parameter int PW     = 3,
    parameter int AIW    = 1,
    parameter int IXW    = 3,
    parameter int IW     = 18,
    parameter int PSLOTS = 2,
    parameter int MAXI   = 8,
    localparam int PAW   = LW + SW + PW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xp_valid,
    input  logic [LW-1:0]  xp_label,
    output logic           host_hold,
    output logic           interactive,
    output logic           brk_valid,
    output logic [LW-1:0]  brk_label,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [PAW-1:0] cmd_addr,
    input  logic [IW-1:0]  cmd_data,
    output logic           rsp_valid,
    output logic           rsp_ok,
    output logic [VW-1:0]  rsp_data,
    output logic [PAW-1:0] pm_raddr,
    input  logic [IW-1:0]  pm_rdata,
    output logic           pm_we,
    output logic [VAW-1:0] ra_addr,
    output logic [VAW-1:0] rb_addr,
    output logic [VAW-1:0] rd_dir_addr,
    input  logic [VW-1:0]  va,
    input  logic [VW-1:0]  vb,
    input  logic [VW-1:0]  vd,
    output logic           c_we,
    output logic [VAW-1:0] c_addr,
    output logic [VW-1:0]  c_wdata,
    output logic           a_we,
    output logic [AIW-1:0] a_id,
    output logic [IXW-1:0] a_idx,
    output logic [VW-1:0]  a_wdata,
    input  logic [VW-1:0]  a_rdata
);
    import dbgc_pkg::*;

    st_e             st;
    logic [LW-1:0]   lbl;
    logic [SW-1:0]   slot;
    logic [PW-1:0]   pc;
    logic            flag;      // 1 = +1, 0 = -1
    logic            brk_any;
    op_e             op;
    logic [VW-1:0]   imm;
    logic [PW+VW:0]  npc;
    logic            term, over, slot_end, slot_brk, last_slot, accept;
    cmd_e            cop;

    assign cop     = cmd_e'(cmd_op);
    assign op      = op_e'(pm_rdata[IW-1 -: 4]);
    assign ra_addr = pm_rdata[IW-5 -: VAW];
    assign rb_addr = pm_rdata[IW-5-VAW -: VAW];
    assign imm     = pm_rdata[VW-1:0];
    assign pm_raddr    = {lbl, slot, pc};
    assign rd_dir_addr = cmd_addr[VAW-1:0];
    assign host_hold   = (st != ST_BATCH);
    assign interactive = (st == ST_INTER);

    // Next instruction index: forward-only skips
    always_comb begin
        npc = {{(VW+1){1'b0}}, pc} + 1'b1;
        if ((op == OP_IF && !flag) || op == OP_SKIP)
            npc = npc + {{(PW+1){1'b0}}, imm};
    end

    assign term      = (op == OP_CONT) || (op == OP_BRK) || (pc == '0 && op == OP_EMPTY);
    assign over      = !term && (npc >= (PW+VW+1)'(MAXI));
    assign slot_end  = term || over;
    assign slot_brk  = (op == OP_BRK) || over;
    assign last_slot = (slot == SW'(PSLOTS-1));
    assign accept    = (cop == CMD_READ) || (st == ST_INTER);
    assign pm_we     = cmd_valid && cop == CMD_PLACE && st == ST_INTER;

    // Array access driven by the running instruction
    assign a_we    = (st == ST_RUN) && (op == OP_AST);
    assign a_id    = imm[AIW-1:0];
    assign a_idx   = vb[IXW-1:0];
    assign a_wdata = va;

    // Controller counter write: running instruction or director write
    always_comb begin
        c_we    = 1'b0;
        c_addr  = ra_addr;
        c_wdata = '0;
        if (st == ST_RUN) begin
            case (op)
                OP_INC:  begin c_we = 1'b1; c_wdata = va + 1'b1; end
                OP_DEC:  begin c_we = 1'b1; c_wdata = va - 1'b1; end
                OP_SET:  begin c_we = 1'b1; c_wdata = imm;       end
                OP_ALD:  begin c_we = 1'b1; c_wdata = a_rdata;   end
                default: ;
            endcase
        end else if (st == ST_INTER && cmd_valid && cop == CMD_WRITE) begin
            c_we    = 1'b1;
            c_addr  = cmd_addr[VAW-1:0];
            c_wdata = cmd_data[VW-1:0];
        end
    end

    // Mode FSM, sequencer state and director responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_INTER; lbl <= '0; slot <= '0; pc <= '0;
            flag <= 1'b0; brk_any <= 1'b0;
            brk_valid <= 1'b0; brk_label <= '0;
            rsp_valid <= 1'b0; rsp_ok <= 1'b0; rsp_data <= '0;
        end else begin
            brk_valid <= 1'b0;
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                rsp_ok   <= accept;
                rsp_data <= (cop == CMD_READ) ? vd : '0;
            end
            case (st)
                ST_BATCH: if (xp_valid) begin
                    lbl <= xp_label; slot <= '0; pc <= '0;
                    flag <= 1'b0; brk_any <= 1'b0; st <= ST_RUN;
                end
                ST_RUN: begin
                    if (op == OP_CEQ) flag <= (va == imm);
                    if (op == OP_CLT) flag <= (va < imm);
                    if (slot_end) begin
                        pc <= '0; flag <= 1'b0;
                        brk_any <= brk_any | slot_brk;
                        if (last_slot) begin
                            if (brk_any || slot_brk) begin
                                st <= ST_INTER; brk_valid <= 1'b1; brk_label <= lbl;
                            end else begin
                                st <= ST_BATCH;
                            end
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end else begin
                        pc <= npc[PW-1:0];
                    end
                end
                ST_INTER: if (cmd_valid && cop == CMD_RESUME) st <= ST_BATCH;
                default: st <= ST_BATCH;
            endcase
        end
    end

    // Checker-only count of cycles spent in one run
    logic [PW+SW+1:0] run_cyc;
    always_ff @(posedge clk) begin
        if (!rst_n || st != ST_RUN) run_cyc <= '0;
        else                        run_cyc <= run_cyc + 1'b1;
    end

    // R4: a break report coincides with interactive mode
    a_r4_brk_in_inter: assert property (@(posedge clk) disable iff (!rst_n)
        brk_valid |-> interactive);
    // R4: entering interactive mode is always reported
    a_r4_entry_reported: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(interactive) |-> brk_valid);
    // R5: leaving interactive mode needs a resume command
    a_r5_resume_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(interactive) |-> $past(cmd_valid && cop == CMD_RESUME));
    // R6: an accepted place was issued in interactive mode
    a_r6_place_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_valid && cop == CMD_PLACE) && rsp_ok) |-> $past(interactive));
    // R9: a run never outlasts PSLOTS*MAXI instructions
    a_r9_bounded_run: assert property (@(posedge clk) disable iff (!rst_n)
        run_cyc <= (PW+SW+2)'(PSLOTS * MAXI));
endmodule

// File: rtl/dbg_ctrl.sv
// Top of the stored-procedure debug controller.
// Does: connects sequencer, counter file, arrays and procedure memory.
// Assumes: counts are powers of two >= 2 and PAW >= VAW.
module dbg_ctrl #(
    parameter int VW     = 8,
    parameter int NVAR   = 8,
    parameter int NARR   = 2,
    parameter int ADEPTH = 8,
    parameter int NLBL   = 4,
    parameter int PSLOTS = 2,
    parameter int MAXI   = 8,
    localparam int VAW   = $clog2(NVAR),
    localparam int LW    = $clog2(NLBL),
    localparam int SW    = $clog2(PSLOTS),
    localparam int PW    = $clog2(MAXI),
    localparam int AIW   = $clog2(NARR),
    localparam int IXW   = $clog2(ADEPTH),
    localparam int IW    = 4 + 2*VAW + VW,
    localparam int PAW   = LW + SW + PW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           xp_valid,
    input  logic [LW-1:0]  xp_label,
    output logic           host_hold,
    input  logic [VAW-1:0] hv_addr,
    input  logic           hv_we,
    input  logic           hv_inc,
    input  logic [VW-1:0]  hv_wdata,
    output logic [VW-1:0]  hv_rdata,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [PAW-1:0] cmd_addr,
    input  logic [IW-1:0]  cmd_data,
    output logic           rsp_valid,
    output logic           rsp_ok,
    output logic [VW-1:0]  rsp_data,
    output logic           interactive,
    output logic           brk_valid,
    output logic [LW-1:0]  brk_label
);
    localparam int NRD = 4;

    logic [PAW-1:0]          pm_raddr;
    logic [IW-1:0]           pm_rdata;
    logic                    pm_we;
    logic [VAW-1:0]          ra_addr, rb_addr, rd_dir_addr, c_addr;
    logic                    c_we, a_we;
    logic [VW-1:0]           c_wdata, a_wdata, a_rdata;
    logic [AIW-1:0]          a_id;
    logic [IXW-1:0]          a_idx;
    logic [NRD-1:0][VAW-1:0] rd_addr;
    logic [NRD-1:0][VW-1:0]  rd_data;

    assign rd_addr  = {rd_dir_addr, rb_addr, ra_addr, hv_addr};
    assign hv_rdata = rd_data[0];

    dbgc_seq #(.VW(VW), .VAW(VAW), .LW(LW), .SW(SW), .PW(PW), .AIW(AIW),
               .IXW(IXW), .IW(IW), .PSLOTS(PSLOTS), .MAXI(MAXI)) i_seq (
        .clk(clk), .rst_n(rst_n), .xp_valid(xp_valid), .xp_label(xp_label),
        .host_hold(host_hold), .interactive(interactive),
        .brk_valid(brk_valid), .brk_label(brk_label),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .pm_raddr(pm_raddr), .pm_rdata(pm_rdata), .pm_we(pm_we),
        .ra_addr(ra_addr), .rb_addr(rb_addr), .rd_dir_addr(rd_dir_addr),
        .va(rd_data[1]), .vb(rd_data[2]), .vd(rd_data[3]),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .a_we(a_we), .a_id(a_id), .a_idx(a_idx), .a_wdata(a_wdata), .a_rdata(a_rdata)
    );

    dbgc_varfile #(.VW(VW), .NVAR(NVAR), .NRD(NRD)) i_vars (
        .clk(clk), .rst_n(rst_n), .h_block(host_hold),
        .h_we(hv_we), .h_inc(hv_inc), .h_addr(hv_addr), .h_wdata(hv_wdata),
        .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    dbgc_arrfile #(.VW(VW), .NARR(NARR), .ADEPTH(ADEPTH)) i_arr (
        .clk(clk), .rst_n(rst_n), .we(a_we), .id(a_id), .idx(a_idx),
        .wdata(a_wdata), .rdata(a_rdata)
    );

    dbgc_procmem #(.IW(IW), .PAW(PAW)) i_pmem (
        .clk(clk), .rst_n(rst_n), .we(pm_we), .waddr(cmd_addr), .wdata(cmd_data),
        .raddr(pm_raddr), .rdata(pm_rdata)
    );
endmodule

// File: tb/test_dbg_ctrl.sv
`timescale 1ns/1ps
// Directed bench for dbg_ctrl: one task per scenario, each checks its own results.
module test_dbg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xp_valid = 1'b0;
    logic [1:0]  xp_label = '0;
    logic        host_hold;
    logic [2:0]  hv_addr = '0;
    logic        hv_we = 1'b0, hv_inc = 1'b0;
    logic [7:0]  hv_wdata = '0;
    logic [7:0]  hv_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [5:0]  cmd_addr = '0;
    logic [17:0] cmd_data = '0;
    logic        rsp_valid, rsp_ok;
    logic [7:0]  rsp_data;
    logic        interactive, brk_valid;
    logic [1:0]  brk_label;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dbg_ctrl i_dbg_ctrl (
        .clk(clk), .rst_n(rst_n), .xp_valid(xp_valid), .xp_label(xp_label),
        .host_hold(host_hold), .hv_addr(hv_addr), .hv_we(hv_we), .hv_inc(hv_inc),
        .hv_wdata(hv_wdata), .hv_rdata(hv_rdata), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .interactive(interactive), .brk_valid(brk_valid), .brk_label(brk_label)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] ins(input int op, input int a, input int b, input int imm);
        return {op[3:0], a[2:0], b[2:0], imm[7:0]};
    endfunction

    task automatic cmd(input int op, input int addr, input logic [17:0] data,
                       output logic ok, output logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op[1:0]; cmd_addr = addr[5:0]; cmd_data = data;
        @(negedge clk);
        cmd_valid = 1'b0;
        ok = rsp_valid & rsp_ok;
        d  = rsp_data;
    endtask

    task automatic place(input int lb, input int sl, input int ix, input logic [17:0] w);
        logic ok; logic [7:0] d;
        cmd(2, lb*16 + sl*8 + ix, w, ok, d);
        chk("R6 place accepted", ok, 1);
    endtask

    task automatic rdv(input int a, output int v);
        @(negedge clk);
        hv_addr = a[2:0];
        #1 v = hv_rdata;
    endtask

    // Pulse an extension point; optionally drive a host write during the hold
    task automatic trigger(input int lb, input bit hw, input int hwa, input int hwd,
                           output int holds, output bit brk, output int bl);
        @(negedge clk);
        xp_valid = 1'b1; xp_label = lb[1:0];
        @(negedge clk);
        xp_valid = 1'b0;
        if (hw) begin hv_we = 1'b1; hv_addr = hwa[2:0]; hv_wdata = hwd[7:0]; end
        holds = 0; brk = 0; bl = -1;
        for (int i = 0; i < 100; i++) begin
            if (!host_hold) break;
            if (interactive && brk_valid) begin brk = 1; bl = brk_label; break; end
            holds++;
            @(negedge clk);
        end
        hv_we = 1'b0;
    endtask

    task automatic t_reset;
        int v;
        chk("R1 interactive", interactive, 1);
        chk("R1 host_hold", host_hold, 1);
        chk("R1 brk_valid", brk_valid, 0);
        chk("R1 rsp_valid", rsp_valid, 0);
        rdv(3, v); chk("R1 counter zero", v, 0);
    endtask

    task automatic t_load;
        logic ok; logic [7:0] d;
        // label1 slot0: inc v1 twice, dec v2, set v3
        place(1,0,0, ins(2,1,0,0)); place(1,0,1, ins(2,1,0,0));
        place(1,0,2, ins(3,2,0,0)); place(1,0,3, ins(4,3,0,8'h12));
        place(1,0,4, ins(0,0,0,0));
        // label2 slot0: if v1==2 set v4=A1 else set v4=B2
        place(2,0,0, ins(5,1,0,2)); place(2,0,1, ins(7,0,0,2));
        place(2,0,2, ins(4,4,0,8'hA1)); place(2,0,3, ins(8,0,0,1));
        place(2,0,4, ins(4,4,0,8'hB2)); place(2,0,5, ins(0,0,0,0));
        // label2 slot1: if v1<2 set v5 ; then set v6
        place(2,1,0, ins(6,1,0,2)); place(2,1,1, ins(7,0,0,1));
        place(2,1,2, ins(4,5,0,8'hC3)); place(2,1,3, ins(4,6,0,8'hD4));
        place(2,1,4, ins(0,0,0,0));
        // label3 slot0: arrays then break; slot1: inc v7, continue
        place(3,0,0, ins(4,7,0,5)); place(3,0,1, ins(10,3,7,1));
        place(3,0,2, ins(9,0,7,1)); place(3,0,3, ins(1,0,0,0));
        place(3,1,0, ins(2,7,0,0)); place(3,1,1, ins(0,0,0,0));
        cmd(0, 0, '0, ok, d);
        chk("R11 read in interactive ok", ok, 1);
        chk("R11 read data", d, 0);
        cmd(3, 0, '0, ok, d);
        chk("R5 resume ok", ok, 1);
        chk("R5 batch after resume", interactive, 0);
        chk("R5 host released", host_hold, 0);
    endtask

    task automatic t_batch_reject_and_empty;
        logic ok; logic [7:0] d; int h, bl, v; bit b;
        cmd(2, 0, ins(1,0,0,0), ok, d);
        chk("R6 place rejected in batch", ok, 0);
        cmd(1, 1, 18'h3F, ok, d);
        chk("R6 write rejected in batch", ok, 0);
        trigger(0, 0, 0, 0, h, b, bl);
        chk("R2 hold cycles empty label", h, 2);
        chk("R2 no break", b, 0);
        rdv(1, v); chk("R6 rejected write no effect", v, 0);
    endtask

    task automatic t_basic;
        int h, bl, v; bit b; logic ok; logic [7:0] d;
        trigger(1, 0, 0, 0, h, b, bl);
        chk("R3 hold cycles 5 instr + empty slot", h, 6);
        chk("R3 no break", b, 0);
        rdv(1, v); chk("R3 inc", v, 2);
        rdv(2, v); chk("R3 dec", v, 8'hFF);
        rdv(3, v); chk("R3 set", v, 8'h12);
        cmd(0, 3, '0, ok, d);
        chk("R11 read in batch ok", ok, 1);
        chk("R11 read in batch data", d, 8'h12);
    endtask

    task automatic t_cond;
        int h, bl, v; bit b;
        trigger(2, 0, 0, 0, h, b, bl);
        chk("R7 no break", b, 0);
        rdv(4, v); chk("R7 eq true first branch", v, 8'hA1);
        rdv(5, v); chk("R7 lt false skips", v, 0);
        rdv(6, v); chk("R7 after skip", v, 8'hD4);
    endtask

    task automatic t_host_port;
        int h, bl, v; bit b;
        @(negedge clk); hv_addr = 3'd1; hv_we = 1'b1; hv_wdata = 8'h40;
        @(negedge clk); hv_we = 1'b0; hv_inc = 1'b1;
        @(negedge clk); hv_inc = 1'b0;
        rdv(1, v); chk("R10 host write then inc", v, 8'h41);
        // v1=0x41: compare false -> second branch sets v4=B2; host write to v4 blocked
        trigger(2, 1, 4, 8'h77, h, b, bl);
        rdv(4, v); chk("R10 controller wins while held", v, 8'hB2);
        chk("R7 eq false second branch", v, 8'hB2);
    endtask

    task automatic t_break_arrays;
        int h, bl, v; bit b; logic ok; logic [7:0] d;
        trigger(3, 0, 0, 0, h, b, bl);
        chk("R4 break reported", b, 1);
        chk("R4 break label", bl, 3);
        @(negedge clk);
        chk("R4 brk_valid one cycle", brk_valid, 0);
        chk("R5 host held in interactive", host_hold, 1);
        rdv(0, v); chk("R8 array store/load", v, 8'h12);
        rdv(7, v); chk("R4 later slot still ran", v, 6);
        cmd(1, 1, 18'h05, ok, d);
        chk("R5 write ok in interactive", ok, 1);
        cmd(0, 1, '0, ok, d);
        chk("R5 read back", d, 5);
        chk("R5 still held", host_hold, 1);
    endtask

    task automatic t_limit;
        int h, bl, v; bit b; logic ok; logic [7:0] d;
        for (int i = 0; i < 8; i++) place(0, 0, i, ins(2,6,0,0));
        cmd(3, 0, '0, ok, d);
        trigger(0, 0, 0, 0, h, b, bl);
        chk("R9 limit treated as break", b, 1);
        chk("R9 break label", bl, 0);
        rdv(6, v); chk("R9 all 8 instr ran", v, 8'hDC);
        cmd(3, 0, '0, ok, d);
        chk("R5 final resume releases", host_hold, 0);
    endtask

    initial begin : wdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_load;
        t_batch_reject_and_empty;
        t_basic;
        t_cond;
        t_host_port;
        t_break_arrays;
        t_limit;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule